// File: doc/BRIEF.md
# Transmit Deferral Watchdog

This block sits beside an Ethernet MAC transmitter and limits how long a pending frame may wait for the medium. When the transmitter has a frame ready, the block checks carrier sense. If the medium is idle, it grants the send at once. If the medium is busy, it starts a deferral episode and counts bit times, using a one-cycle tick per bit time. If carrier stays busy past a configurable limit of bit times (24,288 by default), the block emits a one-cycle abort pulse and gives up the attempt.

The count is per episode. Releasing the medium, abandoning the request, or a fresh deferral after a collision and back-off each restart it from zero. A check-enable input can switch the watchdog off, so the transmitter waits for as long as carrier stays busy. A transmitter-enable input blocks all granting and deferral.

The controller has five states:
- ST_IDLE waits for a request. It goes to ST_GRANT when carrier is clear, or to ST_DEFER when carrier is busy. Either move needs the transmitter enable.
- ST_DEFER counts ticks. It goes back to ST_IDLE on request or enable loss, to ST_GRANT on carrier drop, and to ST_ABORT when a tick arrives with the count already at the limit and the check enabled.
- ST_GRANT permits the send. It goes to ST_IDLE on request or enable loss. It goes to ST_DEFER on back-off completion while carrier is busy.
- ST_ABORT lasts one cycle. It goes to ST_SPENT while the request is held, otherwise to ST_IDLE.
- ST_SPENT waits for the request to drop, then goes to ST_IDLE.

Top module: `txdefer_guard`

## Requirements
- R1: While reset is high, and after it is released, deferring, tx_permit and xs_abort are all 0 until a request is accepted.
- R2: With tx_en high and crs low, a tx_req seen at an edge in the idle state raises tx_permit after that edge.
- R3: With tx_en high and crs high, a tx_req seen at an edge in the idle state raises deferring after that edge, with the bit-time count at zero.
- R4: The count advances only on edges where bit_tick is 1. With chk_en high, the edge carrying the (LIMIT+1)-th tick of an unbroken episode drops deferring and raises xs_abort for exactly one cycle.
- R5: After an abort, all three outputs stay 0 while tx_req stays high, whatever crs does. Only a request that follows a cycle with tx_req low starts a new attempt.
- R6: With chk_en low, xs_abort never rises, and deferring holds for any number of ticks while crs stays high.
- R7: If crs is low at an edge while deferring, with the request and enable still high, tx_permit rises after that edge and the count is cleared.
- R8: While tx_permit is high, a backoff_done pulse with crs high starts a new episode counted from zero, so the episode needs LIMIT+1 fresh ticks to abort. A backoff_done pulse with crs low keeps tx_permit high.
- R9: Dropping tx_req while deferring returns to idle with no abort, and the next episode again needs LIMIT+1 ticks.
- R10: With tx_en low, neither deferring nor tx_permit rises. Dropping tx_en while granted or deferring clears both after that edge.
- R11: Changes of crs and bit_tick while tx_permit is high leave tx_permit high.
- R12: At most one of deferring, tx_permit and xs_abort is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_req | input | 1 | Transmitter has a frame ready |
| crs | input | 1 | Carrier sense, medium busy |
| backoff_done | input | 1 | Pulse when a post-collision back-off has ended |
| chk_en | input | 1 | Enables the excessive-deferral abort |
| tx_en | input | 1 | Transmitter enable |
| deferring | output | 1 | A deferral episode is in progress |
| tx_permit | output | 1 | The transmitter may send |
| xs_abort | output | 1 | One-cycle pulse: deferral limit exceeded |

## Verification
The hardest situation to reach from the ports is a deferral that follows an earlier, partly counted one in the same attempt. Only such a case exposes a counter that accumulates instead of restarting. The stimulus first defers for most of the limit, then drops carrier to obtain the grant. It then raises carrier and pulses backoff_done. The abort must then come only after a full LIMIT+1 fresh ticks. The bench shortens the limit through the parameter, so these edges land within a few dozen cycles. Gated ticks check that idle cycles never count.

// File: rtl/txdg_pkg.sv
package txdg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DEFER = 3'd1,
        ST_GRANT = 3'd2,
        ST_ABORT = 3'd3,
        ST_SPENT = 3'd4
    } txdg_state_e;

    typedef struct packed {
        logic deferring;
        logic permit;
        logic abort;
    } txdg_out_t;

endpackage

// File: rtl/txdg_counter.sv
module txdg_counter #(
    parameter int LIMIT = 24288
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic adv,
    output logic full
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt;

    // Saturating bit-time counter: holds at LIMIT once reached.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (adv && (cnt != LIM_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign full = (cnt == LIM_V);
endmodule

// File: rtl/txdg_fsm.sv
module txdg_fsm
    import txdg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_tick,
    input  logic      tx_req,
    input  logic      crs,
    input  logic      backoff_done,
    input  logic      chk_en,
    input  logic      tx_en,
    input  logic      cnt_full,
    output logic      cnt_clr,
    output logic      cnt_adv,
    output txdg_out_t outs
);
    txdg_state_e state, state_nx;
    logic go;

    assign go = tx_req && tx_en;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    state_nx = crs ? ST_DEFER : ST_GRANT;
                end
            end
            ST_DEFER: begin
                if (!go) begin
                    state_nx = ST_IDLE;
                end else if (!crs) begin
                    state_nx = ST_GRANT;
                end else if (bit_tick && cnt_full && chk_en) begin
                    state_nx = ST_ABORT;
                end
            end
            ST_GRANT: begin
                if (!go) begin
                    state_nx = ST_IDLE;
                end else if (backoff_done && crs) begin
                    state_nx = ST_DEFER;
                end
            end
            ST_ABORT: begin
                state_nx = tx_req ? ST_SPENT : ST_IDLE;
            end
            ST_SPENT: begin
                if (!tx_req) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Outputs (Moore)
    always_comb begin
        outs    = '0;
        cnt_clr = 1'b1;
        cnt_adv = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_DEFER: begin
                outs.deferring = 1'b1;
                cnt_clr        = 1'b0;
                cnt_adv        = bit_tick;
            end
            ST_GRANT: outs.permit = 1'b1;
            ST_ABORT: outs.abort  = 1'b1;
            ST_SPENT: ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/txdefer_guard.sv
module txdefer_guard
    import txdg_pkg::*;
#(
    parameter int LIMIT = 24288
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic tx_req,
    input  logic crs,
    input  logic backoff_done,
    input  logic chk_en,
    input  logic tx_en,
    output logic deferring,
    output logic tx_permit,
    output logic xs_abort
);
    logic      cnt_clr, cnt_adv, cnt_full;
    txdg_out_t outs;

    txdg_counter #(.LIMIT(LIMIT)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .clr  (cnt_clr),
        .adv  (cnt_adv),
        .full (cnt_full)
    );

    txdg_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .bit_tick     (bit_tick),
        .tx_req       (tx_req),
        .crs          (crs),
        .backoff_done (backoff_done),
        .chk_en       (chk_en),
        .tx_en        (tx_en),
        .cnt_full     (cnt_full),
        .cnt_clr      (cnt_clr),
        .cnt_adv      (cnt_adv),
        .outs         (outs)
    );

    assign deferring = outs.deferring;
    assign tx_permit = outs.permit;
    assign xs_abort  = outs.abort;
endmodule

// File: rtl/txdefer_guard_chk.sv
module txdefer_guard_chk (
    input logic clk,
    input logic rst,
    input logic bit_tick,
    input logic tx_req,
    input logic crs,
    input logic chk_en,
    input logic tx_en,
    input logic deferring,
    input logic tx_permit,
    input logic xs_abort
);
    a_r12_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({deferring, tx_permit, xs_abort}));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        xs_abort |=> !xs_abort);

    a_r4_abort_source: assert property (@(posedge clk) disable iff (rst)
        xs_abort |-> $past(deferring && bit_tick && crs && tx_req));

    a_r6_check_gate: assert property (@(posedge clk) disable iff (rst)
        xs_abort |-> $past(chk_en));

    a_r10_disabled: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (!tx_permit && !deferring));

    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (deferring && tx_req && tx_en && !crs) |=> tx_permit);

    a_r9_abandon: assert property (@(posedge clk) disable iff (rst)
        (deferring && !tx_req) |=> (!deferring && !xs_abort));
endmodule

bind txdefer_guard txdefer_guard_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_tick  (bit_tick),
    .tx_req    (tx_req),
    .crs       (crs),
    .chk_en    (chk_en),
    .tx_en     (tx_en),
    .deferring (deferring),
    .tx_permit (tx_permit),
    .xs_abort  (xs_abort)
);

// File: tb/txdefer_guard_test.sv
module txdefer_guard_test;
    localparam int LIM = 10;

    typedef struct {
        logic [2:0] exp;   // {deferring, tx_permit, xs_abort}
        int         rid;
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 0, tx_req = 0, crs = 0, backoff_done = 0, chk_en = 1, tx_en = 1;
    logic deferring, tx_permit, xs_abort;

    int tests = 0;
    int fails = 0;
    bit done  = 0;
    item_t q[$];

    always #5 clk = ~clk;

    txdefer_guard #(.LIMIT(LIM)) uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_req(tx_req), .crs(crs),
        .backoff_done(backoff_done), .chk_en(chk_en), .tx_en(tx_en),
        .deferring(deferring), .tx_permit(tx_permit), .xs_abort(xs_abort)
    );

    // Driver: set inputs for the next edge and queue the outputs expected after it.
    task automatic drv(input logic rq, input logic cs, input logic tk, input logic bo,
                       input logic ce, input logic en, input logic [2:0] exp, input int rid);
        item_t it;
        @(negedge clk);
        tx_req = rq; crs = cs; bit_tick = tk; backoff_done = bo; chk_en = ce; tx_en = en;
        it.exp = exp; it.rid = rid;
        q.push_back(it);
    endtask

    // Monitor: compare shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            tests++;
            if ({deferring, tx_permit, xs_abort} !== it.exp) begin
                fails++;
                $display("FAIL R%0d: got {def,perm,abort}=%b expected %b at %0t",
                         it.rid, {deferring, tx_permit, xs_abort}, it.exp, $time);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) drv(1, 1, 1, 0, 1, 1, 3'b000, 1);
        @(negedge clk); rst = 1'b0; tx_req = 0;
        drv(0, 0, 0, 0, 1, 1, 3'b000, 1);

        // R2 / R11: immediate grant, crs and ticks ignored while granted
        drv(1, 0, 0, 0, 1, 1, 3'b010, 2);
        drv(1, 1, 1, 0, 1, 1, 3'b010, 11);
        drv(1, 0, 1, 0, 1, 1, 3'b010, 11);
        drv(0, 0, 0, 0, 1, 1, 3'b000, 2);

        // R3 / R4: full episode, abort on tick LIM+1; R5 spent until req drops
        drv(1, 1, 0, 0, 1, 1, 3'b100, 3);
        for (int k = 1; k <= LIM; k++) drv(1, 1, 1, 0, 1, 1, 3'b100, 4);
        drv(1, 1, 1, 0, 1, 1, 3'b001, 4);
        drv(1, 1, 1, 0, 1, 1, 3'b000, 5);
        drv(1, 0, 0, 0, 1, 1, 3'b000, 5);
        drv(0, 0, 0, 0, 1, 1, 3'b000, 5);
        drv(1, 0, 0, 0, 1, 1, 3'b010, 5);
        drv(0, 0, 0, 0, 1, 1, 3'b000, 5);

        // R4: gated ticks, only tick edges count
        drv(1, 1, 0, 0, 1, 1, 3'b100, 4);
        for (int k = 1; k <= 2 * LIM + 1; k++)
            drv(1, 1, logic'(k % 2), 0, 1, 1, (k == 2 * LIM + 1) ? 3'b001 : 3'b100, 4);
        drv(0, 1, 0, 0, 1, 1, 3'b000, 4);

        // R7 / R8: partial defer, release, back-off re-defer counts from zero
        drv(1, 1, 0, 0, 1, 1, 3'b100, 8);
        for (int k = 1; k <= LIM - 2; k++) drv(1, 1, 1, 0, 1, 1, 3'b100, 8);
        drv(1, 0, 1, 0, 1, 1, 3'b010, 7);
        drv(1, 1, 1, 0, 1, 1, 3'b010, 11);
        drv(1, 1, 0, 1, 1, 1, 3'b100, 8);
        for (int k = 1; k <= LIM; k++) drv(1, 1, 1, 0, 1, 1, 3'b100, 8);
        drv(1, 1, 1, 0, 1, 1, 3'b001, 8);
        drv(0, 0, 0, 0, 1, 1, 3'b000, 8);

        // R6: check disabled, defers past the limit, then released
        drv(1, 1, 0, 0, 0, 1, 3'b100, 6);
        for (int k = 1; k <= 3 * LIM; k++) drv(1, 1, 1, 0, 0, 1, 3'b100, 6);
        drv(1, 0, 1, 0, 0, 1, 3'b010, 6);
        drv(0, 0, 0, 0, 1, 1, 3'b000, 6);

        // R9: abandon mid-episode, next episode gets the full count
        drv(1, 1, 0, 0, 1, 1, 3'b100, 9);
        for (int k = 1; k <= LIM - 4; k++) drv(1, 1, 1, 0, 1, 1, 3'b100, 9);
        drv(0, 1, 1, 0, 1, 1, 3'b000, 9);
        drv(1, 1, 1, 0, 1, 1, 3'b100, 9);
        for (int k = 1; k <= LIM; k++) drv(1, 1, 1, 0, 1, 1, 3'b100, 9);
        drv(1, 1, 1, 0, 1, 1, 3'b001, 9);
        drv(0, 0, 0, 0, 1, 1, 3'b000, 9);

        // R10: transmitter disabled
        drv(1, 1, 1, 0, 1, 0, 3'b000, 10);
        drv(1, 0, 1, 0, 1, 0, 3'b000, 10);
        drv(1, 0, 0, 0, 1, 1, 3'b010, 10);
        drv(1, 0, 0, 1, 1, 1, 3'b010, 8);   // R8: back-off with idle medium keeps grant
        drv(1, 0, 0, 0, 1, 0, 3'b000, 10);
        drv(1, 1, 0, 0, 1, 1, 3'b100, 10);
        drv(1, 1, 1, 0, 1, 0, 3'b000, 10);
        drv(0, 0, 0, 0, 1, 1, 3'b000, 10);

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule